// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two 32-bit buses, called side A and side B, and moves data in either direction. The data is split into four 8-bit lanes, and each lane is controlled on its own. A lane is either isolated, driving side B, or driving side A. The driven side shows one of two things: the live value from the other bus, or a value held in one of the lane's two storage registers. One register is loaded from side A and the other from side B. Connect the same control to all four lanes and the block acts as one 32-bit transceiver.

The buses are modelled without tristate nets. Each side has an input vector and an output vector, plus one drive-enable bit per lane. Logic around the block, or a pad ring, uses the drive-enable bit to decide who owns the wire. The capture controls are sampled on the common system clock. With the default `EDGE_MODE=1`, a register loads on a rising edge seen on its capture line. With `EDGE_MODE=0`, the capture line is a single-cycle strobe, and the register loads in every cycle the strobe is high. The output multiplexers are purely combinational, so the live path adds no latency.

Top module: `bus_xcvr_reg`

## Requirements
- R1: When `rst_n` is low, both storage registers of every lane are cleared to zero. A lane set to stored mode right after reset drives zero.
- R2: When `iso[i]` is 1, lane i is isolated. `a_drv[i]` and `b_drv[i]` are 0, and that lane's bits of `a_out` and `b_out` are zero.
- R3: When `iso[i]` is 0 and `to_b[i]` is 1, `b_drv[i]` is 1 and `a_drv[i]` is 0.
- R4: When `iso[i]` is 0 and `to_b[i]` is 0, `a_drv[i]` is 1 and `b_drv[i]` is 0.
- R5: While side B of lane i is driven and `b_pick_reg[i]` is 0, that lane's slice of `b_out` equals the same slice of `a_in`, without inversion, in the same cycle. On a side that is not driven, the output slice is zero.
- R6: While side B of lane i is driven and `b_pick_reg[i]` is 1, that lane's slice of `b_out` equals the lane's A-side register.
- R7: While side A of lane i is driven, that lane's slice of `a_out` equals the slice of `b_in` when `a_pick_reg[i]` is 0. It equals the lane's B-side register when `a_pick_reg[i]` is 1.
- R8: With `EDGE_MODE=1`, the A-side register loads the slice of `a_in` at the clock edge where `grab_a[i]` is sampled 1 after having been sampled 0. A capture line held at 1 does not reload the register. The B-side register behaves the same way with `grab_b[i]` and `b_in`. The new value is visible from the next cycle.
- R9: Loading happens whatever the values of `iso` and `to_b`.
- R10: Lane i covers bits 8i to 8i+7 of every data vector. Its controls affect only those bits.
- R11: In any lane, at most one of `a_drv[i]` and `b_drv[i]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iso | input | LANES | Per-lane isolate; 1 disables both sides |
| to_b | input | LANES | Per-lane direction; 1 drives side B, 0 drives side A |
| grab_a | input | LANES | Per-lane capture line for the A-side register |
| grab_b | input | LANES | Per-lane capture line for the B-side register |
| b_pick_reg | input | LANES | Per-lane B-side source: 0 live A data, 1 stored A data |
| a_pick_reg | input | LANES | Per-lane A-side source: 0 live B data, 1 stored B data |
| a_in | input | LANES*LANE_W | Value seen on bus A |
| b_in | input | LANES*LANE_W | Value seen on bus B |
| a_out | output | LANES*LANE_W | Value to drive on bus A |
| a_drv | output | LANES | Per-lane drive enable for bus A |
| b_out | output | LANES*LANE_W | Value to drive on bus B |
| b_drv | output | LANES | Per-lane drive enable for bus B |

## Verification
The drive enables and the live and stored selections are due in the same cycle as the inputs that cause them. The bench changes inputs on the falling edge and compares them with its model shortly afterwards, before the next rising edge. A load is due one cycle later. The model updates its register copies only at the rising edge where the capture line goes from sampled low to sampled high. The following comparison then shows whether the stored value was taken from the bus value held at that edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   typedef enum logic [1:0] {
      LM_ISOLATE = 2'd0,
      LM_DRIVE_A = 2'd1,
      LM_DRIVE_B = 2'd2
   } lane_mode_e;

   function automatic lane_mode_e lane_mode(input logic iso, input logic to_b);
      if (iso)       return LM_ISOLATE;
      else if (to_b) return LM_DRIVE_B;
      else           return LM_DRIVE_A;
   endfunction

endpackage

// File: rtl/xcvr_capgen.sv
module xcvr_capgen #(
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic grab,
   output logic load
);
   generate
      if (EDGE_MODE) begin : g_edge
         logic grab_q;
         // starts high so a line already high at reset release is not an edge
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) grab_q <= 1'b1;
            else        grab_q <= grab;
         end
         assign load = grab & ~grab_q;
      end else begin : g_strobe
         assign load = grab;
      end
   endgenerate
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
   import xcvr_pkg::*;
#(
   parameter int       LANE_W    = 8,
   parameter bit       EDGE_MODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iso,
   input  logic              to_b,
   input  logic              grab_a,
   input  logic              grab_b,
   input  logic              b_pick_reg,
   input  logic              a_pick_reg,
   input  logic [LANE_W-1:0] a_in,
   input  logic [LANE_W-1:0] b_in,
   output logic [LANE_W-1:0] a_out,
   output logic              a_drv,
   output logic [LANE_W-1:0] b_out,
   output logic              b_drv
);
   logic              ld_a, ld_b;
   logic [LANE_W-1:0] store_a, store_b;
   lane_mode_e        mode;

   xcvr_capgen #(.EDGE_MODE(EDGE_MODE)) u_cap_a (
      .clk(clk), .rst_n(rst_n), .grab(grab_a), .load(ld_a));
   xcvr_capgen #(.EDGE_MODE(EDGE_MODE)) u_cap_b (
      .clk(clk), .rst_n(rst_n), .grab(grab_b), .load(ld_b));

   // loading ignores the drive mode entirely
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_a <= '0;
         store_b <= '0;
      end else begin
         if (ld_a) store_a <= a_in;
         if (ld_b) store_b <= b_in;
      end
   end

   assign mode = lane_mode(iso, to_b);

   always_comb begin
      a_drv = (mode == LM_DRIVE_A);
      b_drv = (mode == LM_DRIVE_B);
      a_out = '0;
      b_out = '0;
      if (b_drv) b_out = b_pick_reg ? store_a : a_in;
      if (a_drv) a_out = a_pick_reg ? store_b : b_in;
   end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
   parameter int LANES     = 4,
   parameter int LANE_W    = 8,
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0]        iso,
   input  logic [LANES-1:0]        to_b,
   input  logic [LANES-1:0]        grab_a,
   input  logic [LANES-1:0]        grab_b,
   input  logic [LANES-1:0]        b_pick_reg,
   input  logic [LANES-1:0]        a_pick_reg,
   input  logic [LANES*LANE_W-1:0] a_in,
   input  logic [LANES*LANE_W-1:0] b_in,
   output logic [LANES*LANE_W-1:0] a_out,
   output logic [LANES-1:0]        a_drv,
   output logic [LANES*LANE_W-1:0] b_out,
   output logic [LANES-1:0]        b_drv
);
   localparam int BUS_W = LANES * LANE_W;

   if (LANES < 1 || LANES > 64) begin : g_bad_lanes
      $error("bus_xcvr_reg: LANES out of range");
   end
   if (LANE_W < 1 || BUS_W > 4096) begin : g_bad_width
      $error("bus_xcvr_reg: LANE_W out of range");
   end

   // R10: lane i owns bits i*LANE_W +: LANE_W
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      xcvr_lane #(.LANE_W(LANE_W), .EDGE_MODE(EDGE_MODE)) u_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .iso        (iso[i]),
         .to_b       (to_b[i]),
         .grab_a     (grab_a[i]),
         .grab_b     (grab_b[i]),
         .b_pick_reg (b_pick_reg[i]),
         .a_pick_reg (a_pick_reg[i]),
         .a_in       (a_in[i*LANE_W +: LANE_W]),
         .b_in       (b_in[i*LANE_W +: LANE_W]),
         .a_out      (a_out[i*LANE_W +: LANE_W]),
         .a_drv      (a_drv[i]),
         .b_out      (b_out[i*LANE_W +: LANE_W]),
         .b_drv      (b_drv[i])
      );
   end
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [LANES-1:0]        iso,
   input logic [LANES-1:0]        to_b,
   input logic [LANES-1:0]        grab_a,
   input logic [LANES-1:0]        b_pick_reg,
   input logic [LANES-1:0]        a_pick_reg,
   input logic [LANES*LANE_W-1:0] a_in,
   input logic [LANES*LANE_W-1:0] b_in,
   input logic [LANES*LANE_W-1:0] a_out,
   input logic [LANES-1:0]        a_drv,
   input logic [LANES*LANE_W-1:0] b_out,
   input logic [LANES-1:0]        b_drv
);
   for (genvar i = 0; i < LANES; i++) begin : g_chk
      // R11
      one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(a_drv[i] && b_drv[i]));
      // R2
      isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         iso[i] |-> (!a_drv[i] && !b_drv[i]));
      // R3
      drive_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!iso[i] && to_b[i]) |-> b_drv[i]);
      // R4
      drive_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!iso[i] && !to_b[i]) |-> a_drv[i]);
      // R5
      live_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (b_drv[i] && !b_pick_reg[i]) |->
            (b_out[i*LANE_W +: LANE_W] == a_in[i*LANE_W +: LANE_W]));
      // R7
      live_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (a_drv[i] && !a_pick_reg[i]) |->
            (a_out[i*LANE_W +: LANE_W] == b_in[i*LANE_W +: LANE_W]));
      // R8
      hold_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (b_drv[i] && b_pick_reg[i] && !grab_a[i]) |=>
            (!(b_drv[i] && b_pick_reg[i]) || $stable(b_out[i*LANE_W +: LANE_W])));
   end
endmodule

bind bus_xcvr_reg xcvr_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .iso(iso), .to_b(to_b), .grab_a(grab_a),
   .b_pick_reg(b_pick_reg), .a_pick_reg(a_pick_reg), .a_in(a_in), .b_in(b_in),
   .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv));

// File: tb/bus_xcvr_reg_tb.sv
`timescale 1ns/1ps
module bus_xcvr_reg_tb;
   localparam int LANES = 4;
   localparam int LW    = 8;
   localparam int BW    = LANES * LW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [LANES-1:0] iso, to_b, grab_a, grab_b, b_pick_reg, a_pick_reg;
   logic [BW-1:0] a_in, b_in, a_out, b_out;
   logic [LANES-1:0] a_drv, b_drv;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   logic [LW-1:0] m_a[LANES];
   logic [LW-1:0] m_b[LANES];
   logic          m_pa[LANES];
   logic          m_pb[LANES];

   always #5 clk = ~clk;

   bus_xcvr_reg #(.LANES(LANES), .LANE_W(LW), .EDGE_MODE(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .iso(iso), .to_b(to_b), .grab_a(grab_a),
      .grab_b(grab_b), .b_pick_reg(b_pick_reg), .a_pick_reg(a_pick_reg),
      .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_drv(a_drv),
      .b_out(b_out), .b_drv(b_drv));

   task automatic model_reset();
      for (int l = 0; l < LANES; l++) begin
         m_a[l] = '0; m_b[l] = '0; m_pa[l] = 1'b1; m_pb[l] = 1'b1;
      end
   endtask

   // called once per rising edge, with the inputs held at that edge
   task automatic model_edge();
      for (int l = 0; l < LANES; l++) begin
         if (grab_a[l] && !m_pa[l]) m_a[l] = a_in[l*LW +: LW];
         if (grab_b[l] && !m_pb[l]) m_b[l] = b_in[l*LW +: LW];
         m_pa[l] = grab_a[l];
         m_pb[l] = grab_b[l];
      end
   endtask

   task automatic compare(input string phase);
      for (int l = 0; l < LANES; l++) begin
         logic          e_adrv = !iso[l] && !to_b[l];
         logic          e_bdrv = !iso[l] && to_b[l];
         logic [LW-1:0] e_bout = '0;
         logic [LW-1:0] e_aout = '0;
         if (e_bdrv) e_bout = b_pick_reg[l] ? m_a[l] : a_in[l*LW +: LW];
         if (e_adrv) e_aout = a_pick_reg[l] ? m_b[l] : b_in[l*LW +: LW];
         checks++;
         if (a_drv[l] !== e_adrv || b_drv[l] !== e_bdrv) begin
            fails++;
            $display("FAIL %s %s lane %0d drv a/b=%b%b expected %b%b", phase,
                     iso[l] ? "R2" : (to_b[l] ? "R3" : "R4"), l,
                     a_drv[l], b_drv[l], e_adrv, e_bdrv);
         end else if (b_out[l*LW +: LW] !== e_bout) begin
            fails++;
            $display("FAIL %s %s lane %0d b_out=%h expected %h", phase,
                     !e_bdrv ? "R2" : (b_pick_reg[l] ? "R6 R8" : "R5"), l,
                     b_out[l*LW +: LW], e_bout);
         end else if (a_out[l*LW +: LW] !== e_aout) begin
            fails++;
            $display("FAIL %s %s lane %0d a_out=%h expected %h", phase,
                     !e_adrv ? "R2" : "R7 R8", l, a_out[l*LW +: LW], e_aout);
         end
      end
   endtask

   task automatic step(input string phase);
      #2;
      compare(phase);
      @(posedge clk);
      model_edge();
      @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      model_reset();
      iso = '0; to_b = '1; b_pick_reg = '1; a_pick_reg = '1;
      grab_a = '0; grab_b = '0;
      a_in = 32'hA5C3_FF81; b_in = 32'h5A3C_7E18;
      @(negedge clk); @(negedge clk);
      // R1: stored mode straight after reset drives zero
      step("R1");
      rst_n = 1'b1;
      step("R1");
      to_b = '0;
      step("R1");

      // R9: load while isolated, then read back in stored mode
      iso = '1;
      a_in = 32'h1122_3344; b_in = 32'h99AA_BBCC;
      grab_a = '1; grab_b = '1;
      step("R9");
      grab_a = '0; grab_b = '0; a_in = '0; b_in = '0;
      step("R9");
      iso = '0; to_b = 4'b0101;
      step("R9");
      to_b = 4'b1010;
      step("R9");

      // R8: line held high must not reload
      grab_a = '1; a_in = 32'hDEAD_BEEF; to_b = '1;
      step("R8");
      a_in = 32'h0BAD_F00D;
      step("R8");
      step("R8");
      grab_a = '0;
      step("R8");

      // R10: mixed random traffic per lane
      for (int c = 0; c < 3000; c++) begin
         iso        = LANES'($urandom) & LANES'($urandom);
         to_b       = LANES'($urandom);
         grab_a     = LANES'($urandom);
         grab_b     = LANES'($urandom);
         b_pick_reg = LANES'($urandom);
         a_pick_reg = LANES'($urandom);
         a_in       = BW'($urandom);
         b_in       = BW'($urandom);
         step("R10");
      end

      summary();
      done = 1;
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired before the end of the run");
         summary();
         $finish;
      end
   end
endmodule